// File: doc/BRIEF.md
# Pixel-Doubling Raster Image Fetch

This block turns a monochrome image held in a frame memory into the pixel stream for a display raster, and doubles it in both directions on the way. The source image is stored as `SRC_W` pixels per row and `SRC_ROWS` rows. With the default values of 256 and 240, it fills a 512x480 window anchored at the top-left corner of the visible area. Each source pixel covers a 2x2 block on screen. Every scan position outside the window shows black.

The block takes the raster's horizontal and vertical scan counters from an external timing generator. It issues at most one frame-memory read for each horizontal pixel pair and keeps the fetched value in a one-pixel buffer. The second pixel of the pair is then served from that buffer. This leaves every other memory cycle free for another agent, such as a capture path writing new image data.

The memory is a synchronous single-port byte array with one cycle of read latency. It sits outside the block. Output pixels follow the counters by one clock, so each read is launched one cycle before its pixel pair reaches the output.

Top module: `pixdbl_fetch`

## Requirements
- R1: For scan counters (h, v) inside the window (h < 2*SRC_W and v < 2*SRC_ROWS), the output pixel equals the memory byte of source row v>>1 and source column h>>1.
- R2: For scan counters outside the window, the output pixel is the blank value 8'h00. This includes counter values whose low bits would otherwise form a valid address.
- R3: A read strobe (`rd_en` high) is issued only at even h inside the window. That gives exactly SRC_W*2*SRC_ROWS reads per frame, and never two reads on consecutive cycles during a raster scan.
- R4: The odd pixel of each pair repeats the byte fetched for the even pixel of that pair, without a further read.
- R5: The read address is packed as {row, column}: bits [COL_AW-1:0] hold h>>1 and the bits above hold v>>1, with COL_AW = log2(SRC_W).
- R6: The output pixel for the counters presented in cycle t appears after the next rising clock edge. The read for a pair is strobed in the same cycle that its even counter value is presented.
- R7: While `rst_n` is low, the output is blank, whatever the counters show. The replay buffer and the pipeline state are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcnt | input | CNT_W | Horizontal scan counter |
| vcnt | input | CNT_W | Vertical scan counter |
| rd_en | output | 1 | Frame-memory read strobe |
| rd_addr | output | ADDR_W | Frame-memory read address {row, column} |
| rd_data | input | PIX_W | Frame-memory read data, valid one cycle after the strobe |
| pix_out | output | PIX_W | Pixel to the display path, 8'h00 when blank |

## Verification
The bench builds the block with SRC_W=64 and SRC_ROWS=60, which gives a 128x120 window. This reduced size lets complete frames be compared pixel by pixel within the run budget. CNT_W stays at 10, so the counters carry spare high bits beyond the window edge. The bench uses these to drive positions whose low bits alias onto valid addresses and confirms that they blank. Two frames use different memory patterns, and a reset is forced at an odd in-window position. Together these expose a stale or uncleared replay buffer.

// File: rtl/pixdbl_pkg.sv
`timescale 1ns/1ps
package pixdbl_pkg;
   localparam int DEF_SRC_W    = 256;
   localparam int DEF_SRC_ROWS = 240;
   localparam int DEF_PIX_W    = 8;
   localparam int DEF_CNT_W    = 10;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/pixdbl_window.sv
`timescale 1ns/1ps
module pixdbl_window #(
   parameter int CNT_W = 10,
   parameter int WIN_W = 512,
   parameter int WIN_H = 480
) (
   input  logic [CNT_W-1:0] hcnt,
   input  logic [CNT_W-1:0] vcnt,
   output logic             in_win
);
   import pixdbl_pkg::*;

   logic h_ok, v_ok;

   // a power-of-two edge needs only a zero test on the upper counter bits
   generate
      if (is_pow2(WIN_W)) begin : g_h_pow
         localparam int HSH = $clog2(WIN_W);
         assign h_ok = (hcnt >> HSH) == '0;
      end else begin : g_h_cmp
         assign h_ok = hcnt < CNT_W'(WIN_W);
      end
      if (is_pow2(WIN_H)) begin : g_v_pow
         localparam int VSH = $clog2(WIN_H);
         assign v_ok = (vcnt >> VSH) == '0;
      end else begin : g_v_cmp
         assign v_ok = vcnt < CNT_W'(WIN_H);
      end
   endgenerate

   assign in_win = h_ok & v_ok;
endmodule

// File: rtl/pixdbl_addr.sv
`timescale 1ns/1ps
module pixdbl_addr #(
   parameter int COL_AW = 8,
   parameter int ROW_AW = 8,
   localparam int ADDR_W = COL_AW + ROW_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_win,
   input  logic [COL_AW:0]   hlow,
   input  logic [ROW_AW:1]   vrow,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr
);
   // one fetch per pair, issued on the even half
   assign rd_en   = in_win & ~hlow[0];
   assign rd_addr = {vrow, hlow[COL_AW:1]};

   // R3: during a raster scan a fetch is never followed by another fetch
   p_read_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
endmodule

// File: rtl/pixdbl_replay.sv
`timescale 1ns/1ps
module pixdbl_replay #(
   parameter int          PIX_W = 8,
   parameter logic [PIX_W-1:0] BLANK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_win,
   input  logic             odd,
   input  logic [PIX_W-1:0] rd_data,
   output logic [PIX_W-1:0] pix_out
);
   logic             vis_q, odd_q;
   logic [PIX_W-1:0] buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis_q <= 1'b0;
         odd_q <= 1'b0;
         buf_q <= '0;
      end else begin
         vis_q <= in_win;
         odd_q <= odd;
         if (vis_q && !odd_q)
            buf_q <= rd_data;
      end
   end

   always_comb begin
      if (!vis_q)
         pix_out = BLANK;
      else if (odd_q)
         pix_out = buf_q;
      else
         pix_out = rd_data;
   end
endmodule

// File: rtl/pixdbl_fetch.sv
`timescale 1ns/1ps
module pixdbl_fetch #(
   parameter int SRC_W    = pixdbl_pkg::DEF_SRC_W,
   parameter int SRC_ROWS = pixdbl_pkg::DEF_SRC_ROWS,
   parameter int PIX_W    = pixdbl_pkg::DEF_PIX_W,
   parameter int CNT_W    = pixdbl_pkg::DEF_CNT_W,
   localparam int COL_AW  = $clog2(SRC_W),
   localparam int ROW_AW  = $clog2(SRC_ROWS),
   localparam int ADDR_W  = COL_AW + ROW_AW,
   localparam int WIN_W   = 2 * SRC_W,
   localparam int WIN_H   = 2 * SRC_ROWS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  hcnt,
   input  logic [CNT_W-1:0]  vcnt,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [PIX_W-1:0]  rd_data,
   output logic [PIX_W-1:0]  pix_out
);
   import pixdbl_pkg::*;

   localparam logic [PIX_W-1:0] BLANK = '0;

   generate
      if (!is_pow2(SRC_W)) begin : g_bad_w
         $error("SRC_W must be a power of two");
      end
      if (SRC_ROWS < 2) begin : g_bad_rows
         $error("SRC_ROWS must be at least 2");
      end
      if (COL_AW >= CNT_W || ROW_AW >= CNT_W) begin : g_bad_cnt
         $error("CNT_W too narrow for the window");
      end
   endgenerate

   logic in_win;

   pixdbl_window #(.CNT_W(CNT_W), .WIN_W(WIN_W), .WIN_H(WIN_H)) u_win (
      .hcnt   (hcnt),
      .vcnt   (vcnt),
      .in_win (in_win)
   );

   pixdbl_addr #(.COL_AW(COL_AW), .ROW_AW(ROW_AW)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_win  (in_win),
      .hlow    (hcnt[COL_AW:0]),
      .vrow    (vcnt[ROW_AW:1]),
      .rd_en   (rd_en),
      .rd_addr (rd_addr)
   );

   pixdbl_replay #(.PIX_W(PIX_W), .BLANK(BLANK)) u_rep (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_win  (in_win),
      .odd     (hcnt[0]),
      .rd_data (rd_data),
      .pix_out (pix_out)
   );

   // R1: even pixel of a pair shows the byte returned by its own fetch
   p_even_fresh_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !hcnt[0]) |=> (pix_out == rd_data));

   // R2: positions outside the window come out blank one cycle later
   p_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |=> (pix_out == BLANK));

   // R4: odd pixel replays the byte that came back for the preceding fetch
   p_replay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && hcnt[0] && $past(rd_en)) |=> (pix_out == $past(rd_data)));
endmodule

// File: tb/pixdbl_fetch_test.sv
`timescale 1ns/1ps
module pixdbl_fetch_test;
   localparam int SW    = 64;
   localparam int SR    = 60;
   localparam int CW    = 10;
   localparam int WW    = 2 * SW;
   localparam int WH    = 2 * SR;
   localparam int H_TOT = WW + 16;
   localparam int V_TOT = WH + 10;
   localparam int AW    = $clog2(SW) + $clog2(SR);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] hcnt = '0;
   logic [CW-1:0] vcnt = '0;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data = '0;
   logic [7:0]    pix_out;

   int total = 0;
   int bad = 0;
   int seed = 0;
   int reads = 0;
   int ph, pv, pseed;
   bit pvalid = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pixdbl_fetch #(.SRC_W(SW), .SRC_ROWS(SR), .PIX_W(8), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pix_out(pix_out)
   );

   function automatic logic [7:0] fpat(input int a, input int s);
      return 8'((a * 29) ^ (a >> 3) ^ (s * 90));
   endfunction

   // frame memory model: one-cycle synchronous read
   always @(posedge clk) if (rd_en) rd_data <= fpat(int'(rd_addr), seed);

   function automatic bit inwin(input int h, input int v);
      return (h < WW) && (v < WH);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int h, input int v);
      int e;
      bit er;
      @(negedge clk);
      if (pvalid) begin
         if (inwin(ph, pv)) begin
            e = fpat((pv >> 1) * SW + (ph >> 1), pseed);
            // R1 even pixels, R4 odd replayed pixels, R6 one-cycle latency
            chk(pix_out == 8'(e), (ph % 2) ? "R4" : "R1", int'(pix_out), e);
         end else begin
            chk(pix_out == 8'h00, "R2", int'(pix_out), 0);
         end
      end
      hcnt = CW'(h); vcnt = CW'(v);
      ph = h; pv = v; pseed = seed; pvalid = 1;
      #1;
      er = inwin(h, v) && (h % 2 == 0);
      chk(rd_en == er, "R3", int'(rd_en), int'(er));
      if (er) begin
         e = (v >> 1) * SW + (h >> 1);
         chk(int'(rd_addr) == e, "R5", int'(rd_addr), e);
      end
      if (rd_en) reads++;
   endtask

   task automatic frame(input int lines);
      reads = 0;
      for (int v = 0; v < lines; v++)
         for (int h = 0; h < H_TOT; h++) step(h, v);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R7: blank while reset held
      hcnt = CW'(WW); vcnt = '0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(pix_out == 8'h00, "R7", int'(pix_out), 0);
         chk(rd_en == 1'b0, "R7", int'(rd_en), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      ph = WW; pv = 0; pseed = seed; pvalid = 1;

      // full frame, counters include aliasing positions past the window (R2)
      seed = 0;
      frame(V_TOT);
      chk(reads == SW * WH, "R3", reads, SW * WH);

      // partial frame, then reset at an odd in-window position (R7)
      seed = 2;
      frame(4);
      @(negedge clk);
      rst_n = 1'b0; pvalid = 0;
      hcnt = CW'(5); vcnt = CW'(2);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(pix_out == 8'h00, "R7", int'(pix_out), 0);
      end
      hcnt = CW'(WW);
      @(negedge clk);
      rst_n = 1'b1;
      ph = WW; pv = 2; pseed = seed; pvalid = 1;

      // second full frame with a different pattern: stale buffer shows up
      seed = 1;
      frame(V_TOT);
      chk(reads == SW * WH, "R3", reads, SW * WH);
      step(WW, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule